// File: doc/BRIEF.md
# Single-Channel Block Transfer DMA Engine

This block moves a block of words between one peripheral and memory without the CPU touching each word. The CPU loads a start address, a word count and a control word through a small register port. A control write with the start bit set makes the engine request the system bus. Once the bus is granted, the engine drives the memory address, the data and the memory read or write strobe itself. Each word is paced by the peripheral's request line and is confirmed with an acknowledge pulse.

The register port and bus mastership share the grant line. While the grant is low, the CPU owns the bus and can reach the registers. While the grant is high, the engine owns the memory bus and the register port reads as zero. In burst mode the engine keeps the bus until the whole block is done. In cycle-stealing mode it gives the bus back after every word and asks for it again. When the last word has moved, an interrupt line rises and stays high until the CPU writes the control register.

Top module: `dma_engine`

## Requirements
- R1: Register reads need the select and read strobes with the grant low, and return zero otherwise. The read data, zero-extended, depends on the register address: 0 = current address, 1 = remaining count, 2 = control ({mode, direction} in bits 2:1, bit 0 reads 0), 3 = status (bit 0 done, bit 1 busy, bits CW+1:2 the remaining count). After reset all registers read as zero.
- R2: Control write fields are: bit 0 start, bit 1 direction (1 = memory to peripheral using memory reads, 0 = peripheral to memory using memory writes), bit 2 mode (1 = cycle stealing, 0 = burst). Any accepted control write clears done and the interrupt.
- R3: A start with a nonzero count raises the bus request in the cycle after the write. No memory read or write strobe is issued while the grant is low.
- R4: With the grant high, a word moves in each cycle in which the peripheral request is high. In that cycle exactly one memory strobe pulses together with the acknowledge, and the address output equals the address register. Read data is passed to the peripheral and peripheral data is passed to memory.
- R5: Each moved word increments the address register by one (wrapping at 2^AW) and decrements the count by one.
- R6: In burst mode the bus request stays high from the start until the last word, so one grant serves the whole block.
- R7: In cycle-stealing mode the request drops in the cycle after each word. It rises again only after the grant has gone low, so there is one grant per word.
- R8: Done and the interrupt are set on the clock edge that moves the last word. They hold until a control write.
- R9: While busy, every register write is ignored, including a second start.
- R10: A start with a count of zero sets done and the interrupt at once and never raises the bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | Register port select |
| regAddr | input | 2 | Register address |
| regRd | input | 1 | Register read strobe |
| regWr | input | 1 | Register write strobe |
| regWdata | input | DW | Register write data |
| regRdata | output | DW | Register read data |
| busReq | output | 1 | Bus request to the CPU |
| busGrant | input | 1 | Bus grant from the CPU |
| memAddr | output | AW | Memory address driven as bus master |
| memWdata | output | DW | Memory write data |
| memRdata | input | DW | Memory read data |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| perReq | input | 1 | Peripheral word request |
| perAck | output | 1 | Peripheral word acknowledge |
| perWdata | input | DW | Data from the peripheral |
| perRdata | output | DW | Data to the peripheral |
| irq | output | 1 | Block complete interrupt |

## Verification
The bench uses the defaults AW=8, DW=16 and CW=8. The 8-bit address lets a block that starts at 0xFF wrap through zero, so address wrap is covered. The 8-bit count keeps every block short enough to check word by word against a 256-word memory model. A bench-side arbiter that can hold back the grant reaches the busy-but-not-granted window, where register writes must be ignored and no strobe may appear. Peripheral request patterns with gaps show that a burst keeps a single grant, while cycle stealing takes one grant per word.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int RAW = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2,
    ST_REL  = 2'd3
  } dmaState_t;

  typedef struct packed {
    logic wrAddr;
    logic wrCount;
    logic wrCtrl;
    logic step;
    logic setDone;
    logic busy;
  } dmaStrobes_t;
endpackage

// File: rtl/dma_dpath.sv
module dma_dpath
  import dma_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dmaStrobes_t       stb,
  input  logic              rdEn,
  input  logic [RAW-1:0]    regAddr,
  input  logic [DW-1:0]     regWdata,
  output logic [DW-1:0]     regRdata,
  output logic [AW-1:0]     addrOut,
  output logic              dirRead,
  output logic              modeSteal,
  output logic              countZero,
  output logic              countOne,
  output logic              done
);
  localparam logic [CW-1:0] ONE_C = CW'(1);
  localparam logic [AW-1:0] ONE_A = AW'(1);

  logic [AW-1:0] addrReg;
  logic [CW-1:0] countReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addrReg   <= '0;
      countReg  <= '0;
      dirRead   <= 1'b0;
      modeSteal <= 1'b0;
      done      <= 1'b0;
    end else begin
      if (stb.wrAddr) addrReg <= regWdata[AW-1:0];
      else if (stb.step) addrReg <= addrReg + ONE_A;
      if (stb.wrCount) countReg <= regWdata[CW-1:0];
      else if (stb.step) countReg <= countReg - ONE_C;
      if (stb.wrCtrl) begin
        dirRead   <= regWdata[1];
        modeSteal <= regWdata[2];
      end
      if (stb.setDone) done <= 1'b1;
      else if (stb.wrCtrl) done <= 1'b0;
    end
  end

  assign addrOut   = addrReg;
  assign countZero = (countReg == '0);
  assign countOne  = (countReg == ONE_C);

  always_comb begin
    regRdata = '0;
    if (rdEn) begin
      case (regAddr)
        2'd0: regRdata[AW-1:0] = addrReg;
        2'd1: regRdata[CW-1:0] = countReg;
        2'd2: regRdata[2:1]    = {modeSteal, dirRead};
        default: regRdata[CW+1:0] = {countReg, stb.busy, done};
      endcase
    end
  end

  assert_step_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stb.step |=> (addrReg == $past(addrReg) + ONE_A) && (countReg == $past(countReg) - ONE_C));
  assert_busy_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.busy && !stb.step) |=> ($stable(addrReg) && $stable(countReg) && $stable(modeSteal) && $stable(dirRead)));
  assert_done_on_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> countZero);
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           regSel,
  input  logic           regWr,
  input  logic [RAW-1:0] regAddr,
  input  logic           startBit,
  input  logic           busGrant,
  input  logic           perReq,
  input  logic           dirRead,
  input  logic           modeSteal,
  input  logic           countZero,
  input  logic           countOne,
  output dmaStrobes_t    stb,
  output logic           busReq,
  output logic           memRd,
  output logic           memWr,
  output logic           perAck
);
  dmaState_t state, nextState;
  logic      wrOk, startGo, word;

  assign wrOk    = regSel && regWr && !busGrant && (state == ST_IDLE);
  assign startGo = wrOk && (regAddr == 2'd2) && startBit;
  assign word    = (state == ST_XFER) && busGrant && perReq && !countZero;

  always_comb begin
    stb         = '0;
    stb.wrAddr  = wrOk && (regAddr == 2'd0);
    stb.wrCount = wrOk && (regAddr == 2'd1);
    stb.wrCtrl  = wrOk && (regAddr == 2'd2);
    stb.step    = word;
    stb.setDone = (startGo && countZero) || (word && countOne);
    stb.busy    = (state != ST_IDLE);
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE: if (startGo && !countZero) nextState = ST_REQ;
      ST_REQ:  if (busGrant) nextState = ST_XFER;
      ST_XFER: if (word && (countOne || modeSteal)) nextState = ST_REL;
      default: if (!busGrant) nextState = countZero ? ST_IDLE : ST_REQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  assign busReq = (state == ST_REQ) || (state == ST_XFER);
  assign memRd  = word && dirRead;
  assign memWr  = word && !dirRead;
  assign perAck = word;

  assert_steal_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (perAck && modeSteal) |=> !busReq);
  assert_burst_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (perAck && !modeSteal && !countOne) |=> busReq);
  assert_empty_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (startGo && countZero) |=> !busReq);
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           regSel,
  input  logic [RAW-1:0] regAddr,
  input  logic           regRd,
  input  logic           regWr,
  input  logic [DW-1:0]  regWdata,
  output logic [DW-1:0]  regRdata,
  output logic           busReq,
  input  logic           busGrant,
  output logic [AW-1:0]  memAddr,
  output logic [DW-1:0]  memWdata,
  input  logic [DW-1:0]  memRdata,
  output logic           memRd,
  output logic           memWr,
  input  logic           perReq,
  output logic           perAck,
  input  logic [DW-1:0]  perWdata,
  output logic [DW-1:0]  perRdata,
  output logic           irq
);
  dmaStrobes_t stb;
  logic dirRead, modeSteal, countZero, countOne, done;

  dma_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .regSel(regSel), .regWr(regWr), .regAddr(regAddr),
    .startBit(regWdata[0]), .busGrant(busGrant), .perReq(perReq),
    .dirRead(dirRead), .modeSteal(modeSteal), .countZero(countZero), .countOne(countOne),
    .stb(stb), .busReq(busReq), .memRd(memRd), .memWr(memWr), .perAck(perAck)
  );

  dma_dpath #(.AW(AW), .DW(DW), .CW(CW)) u_dpath (
    .clk(clk), .rst_n(rst_n), .stb(stb), .rdEn(regSel && regRd && !busGrant),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .addrOut(memAddr),
    .dirRead(dirRead), .modeSteal(modeSteal), .countZero(countZero), .countOne(countOne),
    .done(done)
  );

  assign memWdata = perWdata;
  assign perRdata = memRdata;
  assign irq      = done;

  assert_strobe_needs_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (memRd || memWr) |-> (busGrant && busReq));
  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (memRd || memWr) |-> (perAck && !(memRd && memWr)));
endmodule

// File: tb/sim_dma_engine.sv
module sim_dma_engine;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       dir;
    logic       steal;
    logic [7:0] addr;
    logic [7:0] cnt;
    logic [7:0] pat;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'h80, 8'd4, 8'hFF},
    '{1'b1, 1'b0, 8'h10, 8'd6, 8'hFF},
    '{1'b0, 1'b1, 8'h90, 8'd3, 8'hFF},
    '{1'b1, 1'b1, 8'h20, 8'd5, 8'hA5},
    '{1'b0, 1'b0, 8'hA0, 8'd7, 8'h3C},
    '{1'b1, 1'b0, 8'hFF, 8'd2, 8'h81},
    '{1'b1, 1'b1, 8'h40, 8'd1, 8'hFF}
  };

  logic clk = 0, rst_n = 0;
  logic regSel = 0, regRd = 0, regWr = 0;
  logic [1:0] regAddr = 0;
  logic [15:0] regWdata = 0, regRdata;
  logic busReq, busGrant, memRd, memWr, perAck, irq;
  logic [7:0] memAddr;
  logic [15:0] memWdata, memRdata, perWdata, perRdata;
  logic perReq = 0;
  logic grantEn = 1;
  logic [7:0] reqPat = 8'h00;
  logic [2:0] cyc = 0;
  logic [15:0] mem [256];
  logic [15:0] sinkBuf [64];
  int srcIdx, sinkIdx, grantRises;
  logic prevGrant;
  int checks = 0, failures = 0;
  logic finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_engine u0 (
    .clk(clk), .rst_n(rst_n), .regSel(regSel), .regAddr(regAddr), .regRd(regRd),
    .regWr(regWr), .regWdata(regWdata), .regRdata(regRdata), .busReq(busReq),
    .busGrant(busGrant), .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memRd(memRd), .memWr(memWr), .perReq(perReq), .perAck(perAck),
    .perWdata(perWdata), .perRdata(perRdata), .irq(irq)
  );

  assign memRdata = mem[memAddr];
  assign perWdata = 16'hC000 | 16'(srcIdx);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 16'h5000 | 16'(i);
      busGrant <= 1'b0; srcIdx <= 0; sinkIdx <= 0; grantRises <= 0; prevGrant <= 1'b0;
    end else begin
      if (memWr) mem[memAddr] <= memWdata;
      busGrant <= busReq && grantEn;
      prevGrant <= busGrant;
      if (busGrant && !prevGrant) grantRises <= grantRises + 1;
      if (perAck) begin
        srcIdx <= srcIdx + 1;
        if (memRd) begin sinkBuf[sinkIdx % 64] <= perRdata; sinkIdx <= sinkIdx + 1; end
      end
    end
  end

  always @(negedge clk) begin
    perReq <= reqPat[cyc];
    cyc <= cyc + 3'd1;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regSel = 1; regWr = 1; regAddr = a; regWdata = d;
    @(negedge clk);
    regSel = 0; regWr = 0; regWdata = 0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    regSel = 1; regRd = 1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regSel = 0; regRd = 0;
  endtask

  task automatic waitIrq(output logic ok);
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (irq) begin ok = 1; break; end
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
  end

  initial begin
    logic [15:0] rd;
    logic ok;
    int srcBase, sinkBase, grantBase;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11-style reset state, covered under R1
    check(!busReq && !irq, "R1 reset outputs", {busReq, irq}, 0);
    regRead(2'd3, rd); check(rd == 0, "R1 reset status", rd, 0);
    regRead(2'd0, rd); check(rd == 0, "R1 reset address", rd, 0);

    // Table walk: R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      t = VECS[v];
      reqPat = t.pat;
      regWrite(2'd0, {8'h00, t.addr});
      regWrite(2'd1, {8'h00, t.cnt});
      srcBase = srcIdx; sinkBase = sinkIdx; grantBase = grantRises;
      regWrite(2'd2, {13'd0, t.steal, t.dir, 1'b1});
      waitIrq(ok);
      check(ok, "R8 irq after block", ok, 1);
      for (int w = 0; w < int'(t.cnt); w++) begin
        if (t.dir) begin
          logic [7:0] ma;
          ma = t.addr + 8'(w);
          check(sinkBuf[(sinkBase + w) % 64] == (16'h5000 | 16'(ma)), "R4 read word",
                sinkBuf[(sinkBase + w) % 64], 16'h5000 | 16'(ma));
        end else begin
          check(mem[8'(t.addr + 8'(w))] == (16'hC000 | 16'(srcBase + w)), "R4 write word",
                mem[8'(t.addr + 8'(w))], 16'hC000 | 16'(srcBase + w));
        end
      end
      if (t.steal)
        check(grantRises - grantBase == int'(t.cnt), "R7 grant per word", grantRises - grantBase, t.cnt);
      else
        check(grantRises - grantBase == 1, "R6 single grant", grantRises - grantBase, 1);
      regRead(2'd0, rd);
      check(rd == {8'h00, 8'(t.addr + t.cnt)}, "R5 final address", rd, 8'(t.addr + t.cnt));
      regRead(2'd3, rd);
      check(rd == 16'h0001, "R8 status done count zero", rd, 1);
      regRead(2'd2, rd);
      check(rd == {13'd0, t.steal, t.dir, 1'b0}, "R1 control readback", rd, {t.steal, t.dir, 1'b0});
    end

    // R8: irq holds, then cleared by control write (R2)
    repeat (20) @(negedge clk);
    check(irq, "R8 irq held", irq, 1);
    regWrite(2'd2, 16'h0000);
    @(negedge clk);
    check(!irq, "R2 control write clears irq", irq, 0);

    // R10: zero count start
    regWrite(2'd1, 16'h0000);
    regWrite(2'd2, 16'h0001);
    check(irq, "R10 immediate done", irq, 1);
    ok = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (busReq) ok = 1; end
    check(!ok, "R10 no bus request", ok, 0);
    regRead(2'd3, rd); check(rd == 16'h0001, "R10 status", rd, 1);

    // R3 and R9: grant withheld
    grantEn = 0; reqPat = 8'hFF;
    regWrite(2'd0, 16'h0030);
    regWrite(2'd1, 16'h0003);
    @(negedge clk);
    regSel = 1; regWr = 1; regAddr = 2'd2; regWdata = 16'h0003;
    @(negedge clk);
    regSel = 0; regWr = 0; regWdata = 0;
    check(busReq, "R3 request after start", busReq, 1);
    check(!irq, "R2 start clears done", irq, 0);
    ok = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (memRd || memWr || perAck) ok = 1; end
    check(!ok, "R3 no strobe without grant", ok, 0);
    regWrite(2'd0, 16'h0077);
    regWrite(2'd1, 16'h0033);
    regWrite(2'd2, 16'h0005);
    regRead(2'd0, rd); check(rd == 16'h0030, "R9 address write ignored", rd, 16'h30);
    regRead(2'd3, rd); check(rd == 16'h000E, "R9 busy status count kept", rd, 16'h0E);
    regRead(2'd2, rd); check(rd == 16'h0002, "R9 control write ignored", rd, 16'h02);
    grantEn = 1;
    waitIrq(ok);
    check(ok, "R8 held block completes", ok, 1);
    regRead(2'd0, rd); check(rd == 16'h0033, "R5 final address held block", rd, 16'h33);

    // R1: reads are zero while granted
    reqPat = 8'h00;
    regWrite(2'd0, 16'h0050);
    regWrite(2'd1, 16'h0002);
    regWrite(2'd2, 16'h0001);
    for (int i = 0; i < 4; i++) @(negedge clk);
    check(busGrant, "R1 bus granted", busGrant, 1);
    regRead(2'd0, rd); check(rd == 0, "R1 read zero while granted", rd, 0);
    reqPat = 8'hFF;
    waitIrq(ok);
    check(ok, "R6 burst resumes after gap", ok, 1);
    regRead(2'd0, rd); check(rd == 16'h0052, "R1 read after release", rd, 16'h52);
    summary();
  end
endmodule